// File: doc/BRIEF.md
# Device ROM Header Validator

This block checks the fixed header at the front of a device ROM image. The image arrives one byte per handshake on a valid/ready stream, beginning at byte 0. The final byte is flagged with `s_last`. The expected image length is a separate input. The block runs two checksums while the bytes pass:

- a CRC-8 over the 64-bit unique identifier in bytes 1 to 8;
- a reflected CRC-32C over the data region, which starts at byte 13.

The block also checks the length field, the stream length and the expected length against each other, and inspects the revision byte.

One cycle after the last byte is accepted, the block pulses `done` together with a fatal-error flag and two warning flags. In the same cycle it publishes the identifier, vendor ID, model ID and revision taken from the header. Those values hold until the next `done`.

Back-pressure rules:

- A byte is taken only on a clock edge where both `s_valid` and `s_ready` are high.
- The source may drop `s_valid` between bytes at any time.
- `s_ready` is low only in the single cycle where `done` is high. This gives one bubble between images.
- `exp_len` must be stable from the first byte of an image until its `done`.

Top module: `rom_hdr_check`

## Requirements
- R1: A byte is consumed only on a clock edge with `s_valid` and `s_ready` both high. Idle cycles with `s_valid` low, inserted anywhere in an image, leave every result unchanged. `s_ready` is high in every cycle except the one where `done` is high.
- R2: `done` is high for exactly one cycle, the cycle after the handshake that carries `s_last`. The status flags and identity fields of that image are valid in that cycle.
- R3: Byte 0 must equal a CRC-8 of bytes 1..8. The CRC-8 uses polynomial 0x07 and start value 0xFF, is computed MSB first with each byte XORed in before shifting, and has no output XOR. A mismatch sets `fatal_err`.
- R4: Bytes 9..12 hold, least significant byte first, the CRC-32C of every byte from byte 13 to the end of the image. That CRC is reflected, uses polynomial 0x82F63B78 in reflected form, starts at all ones and is inverted at the end. A mismatch sets `crc_warn` and does not set `fatal_err`.
- R5: The data length is the low 10 bits of the little-endian 16-bit word in bytes 14..15. The upper 6 bits of that word are ignored. If data length + 13 differs from the number of bytes received, `fatal_err` is set.
- R6: If the number of bytes received differs from `exp_len`, `fatal_err` is set.
- R7: An image of fewer than 22 bytes sets `fatal_err`.
- R8: A revision byte (byte 13) above 2 sets `rev_warn`. Values 0..2 do not set it. `rev_warn` never sets `fatal_err`.
- R9: At `done`, `uid` is bytes 1..8 read little endian, `vendor_id` is bytes 16..17 little endian, `model_id` is bytes 18..19 little endian, and `rom_rev` is byte 13. These outputs hold their values until the next `done`.
- R10: When the image has a length fault (R5, R6 or R7), `crc_warn` and `rev_warn` are both 0.
- R11: After reset, `done`, `fatal_err`, `crc_warn` and `rev_warn` are 0, all identity outputs are 0, and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exp_len | input | 16 | Expected total image length in bytes |
| s_valid | input | 1 | Byte stream valid |
| s_ready | output | 1 | Byte stream ready |
| s_data | input | 8 | Byte stream data |
| s_last | input | 1 | Marks the final byte of an image |
| done | output | 1 | One-cycle pulse: verdict and fields valid |
| fatal_err | output | 1 | Image rejected (length fault or identifier CRC-8 fault) |
| crc_warn | output | 1 | Data CRC-32C mismatch; not fatal |
| rev_warn | output | 1 | Revision byte above 2; not fatal |
| uid | output | 64 | Unique identifier from bytes 1..8 |
| vendor_id | output | 16 | Vendor ID from bytes 16..17 |
| model_id | output | 16 | Model ID from bytes 18..19 |
| rom_rev | output | 8 | Revision byte 13 |

## Verification
Warning gating (R10) is the hardest case to reach from the ports. The header store is not cleared between images, so a short image still sees header bytes left over from the image before it.

The bench provokes this with a run of three images:

1. An image with revision 3 and otherwise correct checksums, which must raise `rev_warn`.
2. A 10-byte image, which must report a fatal error with both warnings clear, even though the stale revision byte is still above 2.
3. An image whose length field disagrees with the number of bytes actually streamed. This exercises a CRC-32C span that does not match the declared data length.

Bubbles are inserted into some images to show that idle cycles do not change any result.

// File: rtl/rhc_pkg.sv
`timescale 1ns/1ps
package rhc_pkg;
  localparam int HDR_BYTES  = 22;
  localparam int DATA_START = 13;
  localparam int LEN_BITS   = 10;
  localparam int REV_MAX    = 2;

  localparam int OFS_UCRC = 0;
  localparam int OFS_UID  = 1;
  localparam int UID_BYTES = 8;
  localparam int OFS_DCRC = 9;
  localparam int OFS_REV  = 13;
  localparam int OFS_LEN  = 14;
  localparam int OFS_VEN  = 16;
  localparam int OFS_MOD  = 18;

  localparam logic [7:0]  CRC8_POLY  = 8'h07;
  localparam logic [7:0]  CRC8_INIT  = 8'hFF;
  localparam logic [31:0] CRC32_POLY = 32'h82F63B78;
  localparam logic [31:0] CRC32_INIT = 32'hFFFF_FFFF;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int i = 0; i < 8; i++)
      r = r[7] ? ((r << 1) ^ CRC8_POLY) : (r << 1);
    return r;
  endfunction

  function automatic logic [31:0] crc32c_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ CRC32_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rhc_hdr_store.sv
`timescale 1ns/1ps
module rhc_hdr_store #(
  parameter int NB = 22,
  parameter int IW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic [IW-1:0]   idx,
  input  logic [7:0]      data,
  output logic [NB*8-1:0] hdr_flat
);
  for (genvar g = 0; g < NB; g++) begin : g_byte
    logic [7:0] b_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          b_q <= '0;
      else if (acc && idx == IW'(g))       b_q <= data;
    end
    assign hdr_flat[g*8 +: 8] = b_q;
  end

  // R9
  hdr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && idx >= IW'(NB)) |=> $stable(hdr_flat));
endmodule

// File: rtl/rhc_crc8_uid.sv
`timescale 1ns/1ps
module rhc_crc8_uid #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    data,
  output logic [7:0]    crc_q
);
  import rhc_pkg::*;
  localparam int FIRST = OFS_UID;
  localparam int LAST  = OFS_UID + UID_BYTES - 1;

  logic in_span;
  assign in_span = (idx >= IW'(FIRST)) && (idx <= IW'(LAST));

  always_ff @(posedge clk) begin
    if (!rst_n)                      crc_q <= CRC8_INIT;
    else if (acc && idx == '0)       crc_q <= CRC8_INIT;
    else if (acc && in_span)         crc_q <= crc8_step(crc_q, data);
  end

  // R3
  uid_crc_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && idx > IW'(LAST)) |=> $stable(crc_q));
endmodule

// File: rtl/rhc_crc32c_data.sv
`timescale 1ns/1ps
module rhc_crc32c_data #(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [IW-1:0] idx,
  input  logic [7:0]    data,
  output logic [31:0]   crc_fin
);
  import rhc_pkg::*;
  logic [31:0] crc_q, crc_nx;
  logic        in_span;

  assign in_span = idx >= IW'(DATA_START);
  assign crc_nx  = crc32c_step(crc_q, data);

  always_ff @(posedge clk) begin
    if (!rst_n)                  crc_q <= CRC32_INIT;
    else if (acc && idx == '0)   crc_q <= CRC32_INIT;
    else if (acc && in_span)     crc_q <= crc_nx;
  end

  // value including the byte on the bus, for use on the final handshake
  assign crc_fin = (acc && in_span) ? ~crc_nx : ~crc_q;

  // R4
  data_crc_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && idx != '0 && idx < IW'(DATA_START)) |=> $stable(crc_q));
endmodule

// File: rtl/rom_hdr_check.sv
`timescale 1ns/1ps
module rom_hdr_check #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] exp_len,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  input  logic             s_last,
  output logic             done,
  output logic             fatal_err,
  output logic             crc_warn,
  output logic             rev_warn,
  output logic [63:0]      uid,
  output logic [15:0]      vendor_id,
  output logic [15:0]      model_id,
  output logic [7:0]       rom_rev
);
  import rhc_pkg::*;
  localparam int LW = CNT_W + 1;

  logic             acc;
  logic [CNT_W-1:0] idx_q;
  logic [LW-1:0]    cnt_fin;
  logic [LW-1:0]    img_len_q;
  logic [HDR_BYTES*8-1:0] hdr;
  logic [7:0]       crc8_q;
  logic [31:0]      crc32_fin;

  assign s_ready = !done;
  assign acc     = s_valid && s_ready;
  assign cnt_fin = {1'b0, idx_q} + LW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)                   idx_q <= '0;
    else if (acc && s_last)       idx_q <= '0;
    else if (acc && idx_q != '1)  idx_q <= idx_q + 1'b1;
  end

  rhc_hdr_store #(.NB(HDR_BYTES), .IW(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .acc(acc), .idx(idx_q), .data(s_data), .hdr_flat(hdr));

  rhc_crc8_uid #(.IW(CNT_W)) u_crc8 (
    .clk(clk), .rst_n(rst_n), .acc(acc), .idx(idx_q), .data(s_data), .crc_q(crc8_q));

  rhc_crc32c_data #(.IW(CNT_W)) u_crc32 (
    .clk(clk), .rst_n(rst_n), .acc(acc), .idx(idx_q), .data(s_data), .crc_fin(crc32_fin));

  // header field decode
  logic [63:0]         f_uid;
  logic [31:0]         f_dcrc;
  logic [15:0]         f_ven, f_mod, f_lenw;
  logic [7:0]          f_ucrc, f_rev;
  logic [LEN_BITS-1:0] f_dlen;
  always_comb begin
    for (int k = 0; k < UID_BYTES; k++)
      f_uid[k*8 +: 8] = hdr[(OFS_UID + k)*8 +: 8];
    for (int k = 0; k < 4; k++)
      f_dcrc[k*8 +: 8] = hdr[(OFS_DCRC + k)*8 +: 8];
    f_ucrc = hdr[OFS_UCRC*8 +: 8];
    f_rev  = hdr[OFS_REV*8 +: 8];
    f_lenw = {hdr[(OFS_LEN+1)*8 +: 8], hdr[OFS_LEN*8 +: 8]};
    f_ven  = {hdr[(OFS_VEN+1)*8 +: 8], hdr[OFS_VEN*8 +: 8]};
    f_mod  = {hdr[(OFS_MOD+1)*8 +: 8], hdr[OFS_MOD*8 +: 8]};
    f_dlen = f_lenw[LEN_BITS-1:0];
  end

  // verdict for the image whose last byte is on the bus
  logic v_short, v_lenfld, v_explen, v_len_bad, v_uid_bad;
  always_comb begin
    v_short   = cnt_fin < LW'(HDR_BYTES);
    v_lenfld  = (LW'(f_dlen) + LW'(DATA_START)) != cnt_fin;
    v_explen  = cnt_fin != {1'b0, exp_len};
    v_len_bad = v_short || v_lenfld || v_explen;
    v_uid_bad = crc8_q != f_ucrc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= 1'b0; fatal_err <= 1'b0; crc_warn <= 1'b0; rev_warn <= 1'b0;
      uid <= '0; vendor_id <= '0; model_id <= '0; rom_rev <= '0; img_len_q <= '0;
    end else if (acc && s_last) begin
      done      <= 1'b1;
      fatal_err <= v_len_bad || v_uid_bad;
      crc_warn  <= !v_len_bad && (crc32_fin != f_dcrc);
      rev_warn  <= !v_len_bad && (f_rev > 8'(REV_MAX));
      uid       <= f_uid;
      vendor_id <= f_ven;
      model_id  <= f_mod;
      rom_rev   <= f_rev;
      img_len_q <= cnt_fin;
    end else begin
      done <= 1'b0;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_valid && s_ready) |=> $stable(idx_q));
  // R6
  len_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fatal_err) |-> (img_len_q == {1'b0, exp_len}));
  // R10
  warn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && img_len_q < LW'(HDR_BYTES)) |-> (fatal_err && !crc_warn && !rev_warn));
  // R9
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(vendor_id) && $stable(model_id) && $stable(uid)));
endmodule

// File: tb/rom_hdr_check_tb.sv
`timescale 1ns/1ps
module rom_hdr_check_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] exp_len = '0;
  logic        s_valid = 1'b0, s_last = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready, done, fatal_err, crc_warn, rev_warn;
  logic [63:0] uid;
  logic [15:0] vendor_id, model_id;
  logic [7:0]  rom_rev;

  int checks = 0, failures = 0;
  logic [7:0] img [0:1199];
  int img_n = 0;

  always #5 clk = ~clk;

  rom_hdr_check u_dut (
    .clk(clk), .rst_n(rst_n), .exp_len(exp_len), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .done(done), .fatal_err(fatal_err),
    .crc_warn(crc_warn), .rev_warn(rev_warn), .uid(uid), .vendor_id(vendor_id),
    .model_id(model_id), .rom_rev(rom_rev));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc8(input int first, input int n);
    logic [7:0] c = 8'hFF;
    for (int i = first; i < first + n; i++) begin
      c = c ^ img[i];
      for (int b = 0; b < 8; b++) c = c[7] ? {c[6:0], 1'b0} ^ 8'h07 : {c[6:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [31:0] ref_crc32c(input int first, input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = first; i < first + n; i++) begin
      c = c ^ {24'd0, img[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? {1'b0, c[31:1]} ^ 32'h82F63B78 : {1'b0, c[31:1]};
    end
    return ~c;
  endfunction

  task automatic build(input int dlen, input logic [7:0] rev, input logic [15:0] ven,
                       input logic [15:0] mdl, input logic [63:0] u, input logic [5:0] hi);
    logic [31:0] c;
    img_n = dlen + 13;
    for (int i = 0; i < img_n; i++) img[i] = 8'((i * 7 + 3) ^ (i >> 3));
    for (int k = 0; k < 8; k++) img[1 + k] = u[k*8 +: 8];
    img[13] = rev;
    img[14] = dlen[7:0];
    img[15] = {hi, dlen[9:8]};
    img[16] = ven[7:0]; img[17] = ven[15:8];
    img[18] = mdl[7:0]; img[19] = mdl[15:8];
    img[0] = ref_crc8(1, 8);
    c = ref_crc32c(13, dlen);
    for (int k = 0; k < 4; k++) img[9 + k] = c[k*8 +: 8];
  endtask

  // stream n bytes; gap>0 inserts idle cycles before every third byte
  task automatic send(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && (i % 3) == 1) begin
        @(negedge clk); s_valid = 1'b0;
        for (int g = 0; g < gap; g++) @(negedge clk);
      end else begin
        @(negedge clk);
      end
      chk("R1 ready during image", s_ready, 1'b1);
      s_valid = 1'b1; s_data = img[i]; s_last = (i == n - 1);
    end
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic expect_result(input string tag, input logic f, input logic cw, input logic rw);
    chk({tag, " R2 done"}, done, 1'b1);
    chk({tag, " R1 ready low at done"}, s_ready, 1'b0);
    chk({tag, " fatal"}, fatal_err, f);
    chk({tag, " crc_warn"}, crc_warn, cw);
    chk({tag, " rev_warn"}, rev_warn, rw);
    @(negedge clk);
    chk({tag, " R2 done falls"}, done, 1'b0);
  endtask

  task automatic t_reset();
    chk("R11 done", done, 0); chk("R11 fatal", fatal_err, 0);
    chk("R11 warns", {crc_warn, rev_warn}, 0); chk("R11 ids", uid ^ {vendor_id, model_id, rom_rev}, 0);
    chk("R11 ready", s_ready, 1);
  endtask

  task automatic t_good();
    build(20, 8'd1, 16'hA1B2, 16'hC3D4, 64'h0123_4567_89AB_CDEF, 6'd0);
    exp_len = 16'(img_n); send(img_n, 0);
    expect_result("R3 R4 good", 0, 0, 0);
    chk("R9 uid", uid, 64'h0123_4567_89AB_CDEF);
    chk("R9 vendor", vendor_id, 16'hA1B2);
    chk("R9 model", model_id, 16'hC3D4);
    chk("R9 rev", rom_rev, 8'd1);
    repeat (4) @(negedge clk);
    chk("R9 vendor held", vendor_id, 16'hA1B2);
  endtask

  task automatic t_min_stall();
    build(9, 8'd2, 16'h1111, 16'h2222, 64'hFEDC_BA98_7654_3210, 6'd0);
    exp_len = 16'(img_n); send(img_n, 2);
    expect_result("R1 R7 min 22 with stalls, rev 2 R8", 0, 0, 0);
    chk("R9 model stall", model_id, 16'h2222);
  endtask

  task automatic t_uid_bad();
    build(30, 8'd0, 16'h5555, 16'h6666, 64'h1, 6'd0);
    img[0] = img[0] ^ 8'h10;
    exp_len = 16'(img_n); send(img_n, 0);
    expect_result("R3 uid crc bad", 1, 0, 0);
  endtask

  task automatic t_crc_bad();
    build(40, 8'd0, 16'h7777, 16'h8888, 64'h2, 6'd0);
    img[30] = img[30] ^ 8'h01;
    exp_len = 16'(img_n); send(img_n, 1);
    expect_result("R4 data crc bad", 0, 1, 0);
    chk("R9 vendor after warn", vendor_id, 16'h7777);
  endtask

  task automatic t_rev3();
    build(12, 8'd3, 16'h9999, 16'hAAAA, 64'h3, 6'd0);
    exp_len = 16'(img_n); send(img_n, 0);
    expect_result("R8 rev 3", 0, 0, 1);
  endtask

  task automatic t_short();
    for (int i = 0; i < 10; i++) img[i] = 8'(i);
    exp_len = 16'd10; send(10, 0);
    expect_result("R7 R10 short", 1, 0, 0);
  endtask

  task automatic t_lenfield();
    build(20, 8'd5, 16'h0, 16'h0, 64'h4, 6'd0);
    exp_len = 16'd30; send(30, 0);
    expect_result("R5 R10 length field", 1, 0, 0);
  endtask

  task automatic t_explen();
    build(25, 8'd0, 16'hBEEF, 16'hCAFE, 64'h5, 6'd0);
    exp_len = 16'(img_n + 1); send(img_n, 0);
    expect_result("R6 expected length", 1, 0, 0);
  endtask

  task automatic t_hibits();
    build(500, 8'd0, 16'h0102, 16'h0304, 64'hDEAD_BEEF_0000_0001, 6'h3F);
    exp_len = 16'(img_n); send(img_n, 0);
    expect_result("R5 upper bits ignored", 0, 0, 0);
    chk("R9 uid hi", uid, 64'hDEAD_BEEF_0000_0001);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_good();
    t_min_stall();
    t_uid_bad();
    t_crc_bad();
    t_rev3();
    t_short();
    t_lenfield();
    t_explen();
    t_hibits();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule